// File: doc/BRIEF.md
# Memory Test Access Multiplexer

This block sits in front of a group of on-chip RAM arrays and decides who drives them. In normal operation a functional port reaches one array at a time through a shared address, write-data and selector bus. When an external memory-test controller needs the arrays, it raises a request. Once the block has handed ownership over, it answers with an acknowledge, and from then on the test-side address, data, enables and selector control the arrays.

The arrays differ in size. Array `i` has `ADDR_W - i*ADDR_STEP` address bits and `DATA_W - i*DATA_STEP` data bits. The shared buses are as wide as the largest array. A broadcast mode drives every array in the same cycle, which gives the worst-case power draw. A hold input blocks every chip select. An active-low test reset returns the ownership logic and the error flags to a clean state. Read data comes back one cycle after the read, zero-extended to the full bus width. An illegal enable combination or an address too large for its target raises a one-cycle error pulse, and no access takes place.

With the default parameters there are three arrays: 64x16, 32x12 and 16x8.

Top module: `mbist_ram_mux`

## Requirements
- R1: `testAck` rises on the second rising clock edge at which `testReq` is sampled high, and falls on the first edge at which `testReq` is sampled low.
- R2: While `testAck` is low, only the functional inputs (`func*`) reach the arrays and every test input is ignored. While `testAck` is high, only the test inputs reach the arrays and every functional input is ignored.
- R3: While `testRstN` is low, `testAck`, `illegalErr` and `addrErr` are cleared at each clock edge, whatever `testReq` and the enables are. After `testRstN` returns high with the request still high, `testAck` comes back after two edges.
- R4: An accepted write (write enable 1, read enable 0) stores the low bits of the write data at the given address of the target array. An accepted read (read enable 1, write enable 0) puts that array's word on `rdData` after the next edge, zero-extended to `DATA_W`. With both enables low no array is accessed.
- R5: In test ownership, `testWrEn` and `testRdEn` high together cause no access to any array, and `illegalErr` is high for exactly the cycle after.
- R6: A selector value `i` below `NUM_ARRAYS` targets array `i`. That array holds `2**(ADDR_W-i*ADDR_STEP)` words of `DATA_W-i*DATA_STEP` bits. A selector value of `NUM_ARRAYS` or more targets no array.
- R7: In test ownership with `testAllCfg` high, an accepted write goes to every array, each keeping its own low data bits, and an accepted read reads every array. `rdData` then returns the word of the array named by `testSel`, or zero if the selector names no array.
- R8: With `ramHold` high no array is accessed, in either ownership.
- R9: A nonzero address bit at or above a target array's address width suppresses the whole access. In test ownership this also makes `addrErr` high for exactly the cycle after. In broadcast mode every array is checked.
- R10: `rdData` keeps its last value through cycles with no accepted read. It reads zero after reset, before any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testRstN | input | 1 | Active-low test reset of the ownership logic and error flags |
| testReq | input | 1 | Request for test ownership |
| testAck | output | 1 | Test controller owns the arrays |
| testAddr | input | ADDR_W | Test address, sized to the deepest array |
| testWrData | input | DATA_W | Test write data, sized to the widest array |
| testWrEn | input | 1 | Test write enable |
| testRdEn | input | 1 | Test read enable |
| testSel | input | SEL_W | Test array selector |
| testAllCfg | input | 1 | Broadcast to all arrays |
| ramHold | input | 1 | Force every chip select low |
| funcAddr | input | ADDR_W | Functional address |
| funcWrData | input | DATA_W | Functional write data |
| funcWrEn | input | 1 | Functional write enable |
| funcRdEn | input | 1 | Functional read enable |
| funcSel | input | SEL_W | Functional array selector |
| rdData | output | DATA_W | Read data of the last accepted read, zero-extended |
| illegalErr | output | 1 | Pulse after a test access with both enables high |
| addrErr | output | 1 | Pulse after a test access with an out-of-range address |

## Verification
The embedded assertions check the handshake timing on every cycle: acknowledge follows the request and drops after it, the test reset clears acknowledge and the flags, and the illegal-enable pulse follows its cause. They also check that chip selects stay low under hold or an illegal enable pair, that at most one chip select is active outside broadcast, and that functional ownership matches a low acknowledge. Some behaviour is visible only as stored contents and read timing, and only the bench's scenarios can show it. This covers which array a write really lands in, per-array data truncation, broadcast writes, range-suppressed and hold-suppressed writes leaving old data intact, and ignored inputs of the non-owning side. The bench checks these against a shadow model of every array.

// File: rtl/mbist_mux_pkg.sv
package mbist_mux_pkg;

  // Default configuration of the array group
  localparam int CFG_ARRAYS = 3;
  localparam int CFG_SEL_W  = (CFG_ARRAYS > 1) ? $clog2(CFG_ARRAYS) : 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic [CFG_ARRAYS-1:0] cs;      // per-array chip select
    logic                  wrEn;    // write (1) or read (0) for selected arrays
    logic                  testOwn; // test side owns the address/data buses
    logic [CFG_SEL_W-1:0]  rdSel;   // array whose read word drives rdData
  } ramStrobe_t;

  function automatic int arrAddrW(input int addrW, input int step, input int idx);
    return addrW - idx * step;
  endfunction

  function automatic int arrDataW(input int dataW, input int step, input int idx);
    return dataW - idx * step;
  endfunction

endpackage

// File: rtl/mbist_mux_ram.sv
module mbist_mux_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cs && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (cs && !we) rdata <= mem[addr];
  end
endmodule

// File: rtl/mbist_mux_ctrl.sv
module mbist_mux_ctrl
  import mbist_mux_pkg::*;
#(
  parameter int NUM_ARRAYS = CFG_ARRAYS,
  parameter int ADDR_W     = 6,
  parameter int ADDR_STEP  = 1,
  parameter int SEL_W      = CFG_SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testRstN,
  input  logic              testReq,
  output logic              testAck,
  input  logic [ADDR_W-1:0] testAddr,
  input  logic              testWrEn,
  input  logic              testRdEn,
  input  logic [SEL_W-1:0]  testSel,
  input  logic              testAllCfg,
  input  logic              ramHold,
  input  logic [ADDR_W-1:0] funcAddr,
  input  logic              funcWrEn,
  input  logic              funcRdEn,
  input  logic [SEL_W-1:0]  funcSel,
  output ramStrobe_t        strobes,
  output logic              illegalErr,
  output logic              addrErr
);
  // Ownership handshake: two-stage request pipeline
  logic reqSeen;
  logic ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSeen <= 1'b0;
      ackQ    <= 1'b0;
    end else if (!testRstN) begin
      reqSeen <= 1'b0;
      ackQ    <= 1'b0;
    end else begin
      reqSeen <= testReq;
      ackQ    <= testReq & reqSeen;
    end
  end

  assign testAck = ackQ;

  // Effective request from the owning side
  logic              own;
  logic [ADDR_W-1:0] effAddr;
  logic              effWe;
  logic              effRe;
  logic [SEL_W-1:0]  effSel;
  logic              allMode;
  logic              opValid;

  always_comb begin
    own     = ackQ;
    effAddr = own ? testAddr : funcAddr;
    effWe   = own ? testWrEn : funcWrEn;
    effRe   = own ? testRdEn : funcRdEn;
    effSel  = own ? testSel  : funcSel;
    allMode = own & testAllCfg;
    opValid = effWe ^ effRe;
  end

  // Per-array target and range decode
  logic [NUM_ARRAYS-1:0] target;
  logic [NUM_ARRAYS-1:0] fits;

  for (genvar i = 0; i < NUM_ARRAYS; i++) begin : g_decode
    localparam int AW_I = arrAddrW(ADDR_W, ADDR_STEP, i);
    if (NUM_ARRAYS == 1) begin : g_single
      assign target[i] = 1'b1;
    end else begin : g_multi
      assign target[i] = allMode | (effSel == SEL_W'(i));
    end
    if (AW_I >= ADDR_W) begin : g_full
      assign fits[i] = 1'b1;
    end else begin : g_part
      assign fits[i] = (effAddr[ADDR_W-1:AW_I] == '0);
    end
  end

  logic                  rangeBad;
  logic                  access;
  logic [NUM_ARRAYS-1:0] csVec;

  always_comb begin
    rangeBad = |(target & ~fits);
    access   = opValid & ~rangeBad & ~ramHold;
    csVec    = access ? target : '0;
  end

  // Read-select register and error pulses
  logic [SEL_W-1:0] rdSelQ;
  logic             illegalQ;
  logic             addrErrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSelQ <= '0;
    end else if (access && effRe) begin
      rdSelQ <= (NUM_ARRAYS == 1) ? '0 : effSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      illegalQ <= 1'b0;
      addrErrQ <= 1'b0;
    end else if (!testRstN) begin
      illegalQ <= 1'b0;
      addrErrQ <= 1'b0;
    end else begin
      illegalQ <= own & testWrEn & testRdEn;
      addrErrQ <= own & opValid & rangeBad;
    end
  end

  assign illegalErr = illegalQ;
  assign addrErr    = addrErrQ;

  always_comb begin
    strobes         = '0;
    strobes.cs      = csVec;
    strobes.wrEn    = effWe;
    strobes.testOwn = own;
    strobes.rdSel   = rdSelQ;
  end

  // Handshake checks
  p_ack_after_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    testAck |-> $past(testReq));
  p_ack_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !testReq |=> !testAck);
  p_test_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    !testRstN |=> (!testAck && !illegalErr && !addrErr));
  p_illegal_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (testRstN && testAck && testWrEn && testRdEn) |=> illegalErr);
  p_illegal_noaccess_r5: assert property (@(posedge clk) disable iff (!rstN)
    (testAck && testWrEn && testRdEn) |-> (csVec == '0));
  p_single_cs_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!testAck || !testAllCfg) |-> $onehot0(csVec));
endmodule

// File: rtl/mbist_mux_datapath.sv
module mbist_mux_datapath
  import mbist_mux_pkg::*;
#(
  parameter int NUM_ARRAYS = CFG_ARRAYS,
  parameter int ADDR_W     = 6,
  parameter int ADDR_STEP  = 1,
  parameter int DATA_W     = 16,
  parameter int DATA_STEP  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobe_t        strobes,
  input  logic [ADDR_W-1:0] testAddr,
  input  logic [DATA_W-1:0] testWrData,
  input  logic [ADDR_W-1:0] funcAddr,
  input  logic [DATA_W-1:0] funcWrData,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] busAddr;
  logic [DATA_W-1:0] busData;

  assign busAddr = strobes.testOwn ? testAddr   : funcAddr;
  assign busData = strobes.testOwn ? testWrData : funcWrData;

  logic [DATA_W-1:0] ramRd [NUM_ARRAYS];

  for (genvar i = 0; i < NUM_ARRAYS; i++) begin : g_array
    localparam int AW_I = arrAddrW(ADDR_W, ADDR_STEP, i);
    localparam int DW_I = arrDataW(DATA_W, DATA_STEP, i);
    logic [DW_I-1:0] rdI;

    mbist_mux_ram #(.AW(AW_I), .DW(DW_I)) u_ram (
      .clk   (clk),
      .rstN  (rstN),
      .cs    (strobes.cs[i]),
      .we    (strobes.wrEn),
      .addr  (busAddr[AW_I-1:0]),
      .wdata (busData[DW_I-1:0]),
      .rdata (rdI)
    );

    assign ramRd[i] = DATA_W'(rdI);
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_ARRAYS; k++) begin
      if (int'(strobes.rdSel) == k) rdData = ramRd[k];
    end
  end
endmodule

// File: rtl/mbist_ram_mux.sv
module mbist_ram_mux
  import mbist_mux_pkg::*;
#(
  parameter int NUM_ARRAYS = CFG_ARRAYS,
  parameter int ADDR_W     = 6,
  parameter int ADDR_STEP  = 1,
  parameter int DATA_W     = 16,
  parameter int DATA_STEP  = 4,
  localparam int SEL_W     = CFG_SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testRstN,
  input  logic              testReq,
  output logic              testAck,
  input  logic [ADDR_W-1:0] testAddr,
  input  logic [DATA_W-1:0] testWrData,
  input  logic              testWrEn,
  input  logic              testRdEn,
  input  logic [SEL_W-1:0]  testSel,
  input  logic              testAllCfg,
  input  logic              ramHold,
  input  logic [ADDR_W-1:0] funcAddr,
  input  logic [DATA_W-1:0] funcWrData,
  input  logic              funcWrEn,
  input  logic              funcRdEn,
  input  logic [SEL_W-1:0]  funcSel,
  output logic [DATA_W-1:0] rdData,
  output logic              illegalErr,
  output logic              addrErr
);
  ramStrobe_t strobes;

  mbist_mux_ctrl #(
    .NUM_ARRAYS (NUM_ARRAYS),
    .ADDR_W     (ADDR_W),
    .ADDR_STEP  (ADDR_STEP),
    .SEL_W      (SEL_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .testRstN   (testRstN),
    .testReq    (testReq),
    .testAck    (testAck),
    .testAddr   (testAddr),
    .testWrEn   (testWrEn),
    .testRdEn   (testRdEn),
    .testSel    (testSel),
    .testAllCfg (testAllCfg),
    .ramHold    (ramHold),
    .funcAddr   (funcAddr),
    .funcWrEn   (funcWrEn),
    .funcRdEn   (funcRdEn),
    .funcSel    (funcSel),
    .strobes    (strobes),
    .illegalErr (illegalErr),
    .addrErr    (addrErr)
  );

  mbist_mux_datapath #(
    .NUM_ARRAYS (NUM_ARRAYS),
    .ADDR_W     (ADDR_W),
    .ADDR_STEP  (ADDR_STEP),
    .DATA_W     (DATA_W),
    .DATA_STEP  (DATA_STEP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .testAddr   (testAddr),
    .testWrData (testWrData),
    .funcAddr   (funcAddr),
    .funcWrData (funcWrData),
    .rdData     (rdData)
  );

  // Cross-module ownership and hold checks
  p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    ramHold |-> (strobes.cs == '0));
  p_func_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
    !testAck |-> !strobes.testOwn);
endmodule

// File: tb/tb_mbist_ram_mux.sv
module tb_mbist_ram_mux;
  localparam int NA = 3;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          testRstN;
  logic          testReq;
  logic          testAck;
  logic [AW-1:0] testAddr;
  logic [DW-1:0] testWrData;
  logic          testWrEn;
  logic          testRdEn;
  logic [SW-1:0] testSel;
  logic          testAllCfg;
  logic          ramHold;
  logic [AW-1:0] funcAddr;
  logic [DW-1:0] funcWrData;
  logic          funcWrEn;
  logic          funcRdEn;
  logic [SW-1:0] funcSel;
  logic [DW-1:0] rdData;
  logic          illegalErr;
  logic          addrErr;

  mbist_ram_mux dut (.*);

  always #10 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [DW-1:0] model [NA][64];
  logic [DW-1:0] expRd;

  function automatic int awOf(int i); return AW - i; endfunction
  function automatic int dwOf(int i); return DW - 4 * i; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One access, driven at a falling edge, checked at the next falling edge.
  task automatic op(bit own, bit we, bit re, int sel, bit all, int addr,
                    logic [DW-1:0] data, bit hold, string tag);
    bit tgt [NA];
    bit bad, acc, opv;
    if (own) begin
      testWrEn = we; testRdEn = re; testSel = SW'(sel); testAllCfg = all;
      testAddr = AW'(addr); testWrData = data;
      funcWrEn = 1'($urandom); funcRdEn = 1'($urandom); funcSel = SW'($urandom);
      funcAddr = AW'($urandom); funcWrData = DW'($urandom);
    end else begin
      funcWrEn = we; funcRdEn = re; funcSel = SW'(sel);
      funcAddr = AW'(addr); funcWrData = data;
      testWrEn = 1'($urandom); testRdEn = 1'($urandom); testSel = SW'($urandom);
      testAllCfg = 1'($urandom); testAddr = AW'($urandom); testWrData = DW'($urandom);
    end
    ramHold = hold;
    opv = we ^ re;
    bad = 1'b0;
    for (int i = 0; i < NA; i++) begin
      tgt[i] = (own && all) || (sel == i);
      if (tgt[i] && (addr >= (1 << awOf(i)))) bad = 1'b1;
    end
    acc = opv && !bad && !hold;
    if (acc && we)
      for (int i = 0; i < NA; i++)
        if (tgt[i]) model[i][addr] = data & DW'((1 << dwOf(i)) - 1);
    if (acc && re) expRd = (sel < NA) ? model[sel][addr] : '0;
    @(negedge clk);
    chk({tag, " R2 ack"}, 32'(testAck), 32'(own));
    chk({tag, " R4/R10 rdData"}, 32'(rdData), 32'(expRd));
    chk({tag, " R5 illegalErr"}, 32'(illegalErr), 32'(own && we && re));
    chk({tag, " R9 addrErr"}, 32'(addrErr), 32'(own && opv && bad));
  endtask

  task automatic randOp(bit own);
    int sel, addr, r;
    bit we, re, all, hold;
    sel  = $urandom % 4;
    all  = own && ($urandom % 6 == 0);
    r    = $urandom % 10;
    we   = (r == 0) || (r >= 2 && r < 6);
    re   = (r == 0) || (r >= 6);
    hold = ($urandom % 12 == 0);
    if ($urandom % 8 == 0) addr = $urandom % 64;
    else if (all || sel >= NA) addr = $urandom % 16;
    else addr = $urandom % (1 << awOf(sel));
    op(own, we, re, sel, all, addr, DW'($urandom), hold, "random");
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 0; testRstN = 1; testReq = 0;
    testAddr = 0; testWrData = 0; testWrEn = 0; testRdEn = 0; testSel = 0;
    testAllCfg = 0; ramHold = 0;
    funcAddr = 0; funcWrData = 0; funcWrEn = 0; funcRdEn = 0; funcSel = 0;
    expRd = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset ack", 32'(testAck), 0);
    chk("R10 reset rdData", 32'(rdData), 0);
    chk("R5 reset illegalErr", 32'(illegalErr), 0);
    chk("R9 reset addrErr", 32'(addrErr), 0);

    // Functional fill of every array (R2, R6)
    for (int i = 0; i < NA; i++)
      for (int a = 0; a < (1 << awOf(i)); a++)
        op(0, 1, 0, i, 0, a, DW'($urandom), 0, "fill R6");
    op(0, 0, 1, 1, 0, 31, '0, 0, "func read R2");
    op(0, 0, 1, 3, 0, 2, '0, 0, "func bad sel R6");

    // Handshake rise (R1)
    testReq = 1;
    testWrEn = 0; testRdEn = 0; funcWrEn = 0; funcRdEn = 0;
    @(negedge clk);
    chk("R1 ack after one edge", 32'(testAck), 0);
    @(negedge clk);
    chk("R1 ack after two edges", 32'(testAck), 1);

    // Directed test-mode cases
    op(1, 1, 0, 0, 0, 63, 16'hBEEF, 0, "R4 write a0");
    op(1, 0, 1, 0, 0, 63, '0, 0, "R4 read a0");
    op(1, 1, 0, 2, 0, 15, 16'hFFA5, 0, "R6 write a2 trunc");
    op(1, 0, 1, 2, 0, 15, '0, 0, "R6 read a2");
    op(1, 0, 0, 1, 0, 3, 16'h1234, 0, "R4 no-op");
    op(1, 1, 0, 2, 0, 16, 16'h5555, 0, "R9 write range");
    op(1, 0, 1, 2, 0, 0, '0, 0, "R9 readback");
    op(1, 1, 1, 1, 0, 4, 16'h7777, 0, "R5 both enables");
    op(1, 0, 1, 1, 0, 4, '0, 0, "R5 readback");
    op(1, 1, 0, 0, 0, 5, 16'hAAAA, 1, "R8 held write");
    op(1, 0, 1, 0, 0, 5, '0, 1, "R8 held read");
    op(1, 0, 1, 0, 0, 5, '0, 0, "R8 readback");
    op(1, 1, 0, 3, 1, 9, 16'hC3C3, 0, "R7 broadcast write");
    op(1, 0, 1, 0, 0, 9, '0, 0, "R7 read a0");
    op(1, 0, 1, 1, 0, 9, '0, 0, "R7 read a1");
    op(1, 0, 1, 2, 1, 9, '0, 0, "R7 broadcast read a2");
    op(1, 1, 0, 0, 1, 20, 16'h0F0F, 0, "R9 broadcast range");
    op(1, 0, 1, 0, 0, 20, '0, 0, "R9 broadcast readback");
    op(1, 1, 0, 3, 0, 1, 16'h9999, 0, "R6 no-target write");
    op(1, 0, 0, 0, 0, 0, '0, 0, "R10 idle holds");

    for (int n = 0; n < 600; n++) randOp(1);

    // Test reset (R3)
    testWrEn = 1; testRdEn = 1; testRstN = 0; ramHold = 0;
    @(negedge clk);
    chk("R3 ack cleared", 32'(testAck), 0);
    chk("R3 illegalErr cleared", 32'(illegalErr), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R3 ack held low", 32'(testAck), 0);
    testWrEn = 0; testRdEn = 0; testRstN = 1;
    @(negedge clk);
    chk("R3 ack after release one edge", 32'(testAck), 0);
    @(negedge clk);
    chk("R3 ack after release two edges", 32'(testAck), 1);

    // Handshake fall (R1)
    testReq = 0;
    @(negedge clk);
    chk("R1 ack drop", 32'(testAck), 0);

    for (int n = 0; n < 400; n++) randOp(0);
    for (int i = 0; i < NA; i++)
      for (int a = 0; a < 8; a++) op(0, 0, 1, i, 0, a, '0, 0, "R2 final readback");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule